// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block holds an 8-bit free-running timer and an 8-bit watchdog counter. A single programmable power-of-two prescaler serves one of them at a time. An 8-bit control register is loaded from a data bus when a write strobe is high. It cannot be read back. Its fields select four things: where the timer's clock comes from (an instruction-cycle tick input or an external pin), which edge of the pin counts, which counter owns the prescaler, and a 3-bit rate code.

The external pin passes through a two-flop synchronizer and then an edge detector, so one qualified edge yields one count event. The same rate code divides the timer by twice what it divides the watchdog by. The counter that does not own the prescaler counts every event undivided. The watchdog counts a free-running tick input and emits a one-cycle timeout pulse when its 8-bit count wraps. A watchdog-clear input restarts both the watchdog and the prescaler.

Top module: `tmr_wdog_pre`

## Requirements
- R1: While reset is active and just after it, every control bit is 1, `tmr_q` is 0, `tmr_ovf` and `wdt_timeout` are 0, and `ext_in_force` is 1.
- R2: When `cfg_we` is high at a rising clock edge, the control register takes `cfg_data`. Bits 7 and 6 are stored but change no behaviour.
- R3: Control bit 5 selects the timer source: 1 counts external-pin edges and 0 counts `cyc_tick` pulses. `ext_in_force` equals bit 5, and `cyc_tick` has no effect while bit 5 is 1.
- R4: Control bit 4 selects the external edge: 1 counts high-to-low and 0 counts low-to-high. The opposite edge has no effect. A pin change first seen at a clock edge moves `tmr_q` at the third rising clock edge counted from that one.
- R5: With control bit 3 at 0, the timer advances once per 2^(code+1) source events, where the code is bits 2:0. The prescaler is assumed to start cleared.
- R6: With control bit 3 at 1, the timer advances by exactly 1 per source event.
- R7: When the timer wraps from 0xFF to 0x00, `tmr_ovf` becomes 1 and stays 1 until `ovf_clr` is pulsed.
- R8: The watchdog counts `wdt_tick` pulses. With bit 3 at 1 the count is divided by 2^code; with bit 3 at 0 it is undivided. `wdt_timeout` is high for exactly one cycle, at the step that wraps the 8-bit count from 255.
- R9: `wdt_clr` zeroes the watchdog count and the prescaler, so the next timeout needs a full 256 divided steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_data | input | 8 | Control register write data |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Free-running watchdog tick, one clock wide |
| wdt_clr | input | 1 | Clear watchdog count and prescaler |
| ovf_clr | input | 1 | Clear the timer overflow flag |
| tmr_q | output | 8 | Timer count |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |
| ext_in_force | output | 1 | High when the pin must act as an input |

## Verification
A tick on `cyc_tick` or `wdt_tick` takes effect at the rising edge where it is high. The bench drives each tick at a falling edge and reads `tmr_q` or `wdt_timeout` at the next falling edge. An external pin change needs three rising edges: two synchronizer flops, then the timer register. The bench checks the count is still unchanged after two edges and has moved after the third. Prescaled results are checked one event before and at the exact event that is due, so an off-by-one ratio shows up.

// File: rtl/tmr_wdog_pre.sv
module tmr_wdog_pre #(
  parameter int TMR_W = 8,
  parameter int WDT_W = 8,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_data,
  input  logic             cyc_tick,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             wdt_clr,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] tmr_q,
  output logic             tmr_ovf,
  output logic             wdt_timeout,
  output logic             ext_in_force
);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;
  localparam logic [WDT_W-1:0] WDT_MAX = '1;

  logic [7:0]       ctl;
  logic [2:0]       sync;
  logic [PRE_W-1:0] pre_cnt;
  logic [WDT_W-1:0] wdt_cnt;

  wire       src_ext  = ctl[5];
  wire       fall_sel = ctl[4];
  wire       pre_wdt  = ctl[3];
  wire [2:0] rate     = ctl[2:0];

  wire rise_ev  = sync[1] & ~sync[2];
  wire fall_ev  = ~sync[1] & sync[2];
  wire src_tick = src_ext ? (fall_sel ? fall_ev : rise_ev) : cyc_tick;

  wire [PRE_W-1:0] mask_t = (PRE_W'(2) << rate) - PRE_W'(1);
  wire [PRE_W-1:0] mask_w = (PRE_W'(1) << rate) - PRE_W'(1);

  wire pre_en   = pre_wdt ? wdt_tick : src_tick;
  wire pre_mask = ((pre_cnt & (pre_wdt ? mask_w : mask_t)) == (pre_wdt ? mask_w : mask_t));
  wire tmr_step = pre_wdt ? src_tick : (src_tick & pre_mask);
  wire wdt_step = pre_wdt ? (wdt_tick & pre_mask) : wdt_tick;

  assign ext_in_force = src_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl  <= 8'hFF;
      sync <= '0;
    end else begin
      if (cfg_we) ctl <= cfg_data;
      sync <= {sync[1:0], ext_pin};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wdt_clr) pre_cnt <= '0;
    else if (pre_en)       pre_cnt <= pre_cnt + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      tmr_ovf <= 1'b0;
    end else begin
      if (tmr_step) tmr_q <= tmr_q + TMR_W'(1);
      if (tmr_step && tmr_q == TMR_MAX) tmr_ovf <= 1'b1;
      else if (ovf_clr)                 tmr_ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wdt_clr) begin
      wdt_cnt     <= '0;
      wdt_timeout <= 1'b0;
    end else begin
      if (wdt_step) wdt_cnt <= wdt_cnt + WDT_W'(1);
      wdt_timeout <= wdt_step && (wdt_cnt == WDT_MAX);
    end
  end
endmodule

module tmr_wdog_pre_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [7:0]       cfg_data,
  input logic             wdt_clr,
  input logic             ovf_clr,
  input logic [TMR_W-1:0] tmr_q,
  input logic             tmr_ovf,
  input logic             wdt_timeout,
  input logic             ext_in_force
);
  AST_TMR_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tmr_q) |-> tmr_q == $past(tmr_q) + TMR_W'(1)); // R6
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == '0 && $past(tmr_q) == '1) |-> tmr_ovf); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_ovf) && !$past(ovf_clr)) |-> tmr_ovf); // R7
  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout); // R8
  AST_CLR_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_timeout); // R9
  AST_PIN_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ext_in_force == $past(cfg_data[5])); // R3
endmodule

bind tmr_wdog_pre tmr_wdog_pre_chk #(.TMR_W(TMR_W)) u_chk (.*);

// File: tb/sim_tmr_wdog_pre.sv
module sim_tmr_wdog_pre;
  logic clk = 0, rst_n = 0, cfg_we = 0, cyc_tick = 0, ext_pin = 0;
  logic wdt_tick = 0, wdt_clr = 0, ovf_clr = 0;
  logic [7:0] cfg_data = 0, tmr_q;
  logic tmr_ovf, wdt_timeout, ext_in_force;
  int nchk = 0, nerr = 0;
  int t0, first;

  always #10 clk = ~clk;

  tmr_wdog_pre u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [7:0] v);
    cfg_data = v; cfg_we = 1; @(negedge clk); cfg_we = 0;
  endtask

  task automatic wclr;
    wdt_clr = 1; @(negedge clk); wdt_clr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc_tick = 1; @(negedge clk); cyc_tick = 0;
    end
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1; repeat (3) @(negedge clk);
      ext_pin = 0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic wdt_run(input int lim, output int f);
    f = -1;
    for (int i = 1; i <= lim; i++) begin
      wdt_tick = 1; @(negedge clk); wdt_tick = 0;
      if (wdt_timeout) begin f = i; break; end
    end
    @(negedge clk);
    chk(!wdt_timeout, "R8 pulse width", wdt_timeout, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tmr_q == 0 && !tmr_ovf && !wdt_timeout, "R1 outputs", tmr_q, 0);
    chk(ext_in_force == 1, "R1 control ones", ext_in_force, 1);
    rst_n = 1; @(negedge clk);
    chk(ext_in_force == 1 && tmr_q == 0, "R1 after release", ext_in_force, 1);

    // R5 timer prescaling sweep over all codes
    for (int r = 0; r < 8; r++) begin
      wcfg(8'(r)); wclr;
      t0 = tmr_q;
      ticks(3 * (2 << r) - 1);
      chk(tmr_q == 8'(t0 + 2), "R5 one short", tmr_q, 8'(t0 + 2));
      ticks(1);
      chk(tmr_q == 8'(t0 + 3), "R5 due", tmr_q, 8'(t0 + 3));
    end

    // R6 undivided timer, R7 wrap and clear
    wcfg(8'h08);
    chk(ext_in_force == 0, "R3 force low", ext_in_force, 0);
    chk(!tmr_ovf, "R7 no ovf yet", tmr_ovf, 0);
    t0 = tmr_q;
    ticks(300);
    chk(tmr_q == 8'(t0 + 300), "R6 count", tmr_q, 8'(t0 + 300));
    chk(tmr_ovf, "R7 ovf set", tmr_ovf, 1);
    ticks(5);
    chk(tmr_ovf, "R7 ovf sticky", tmr_ovf, 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk(!tmr_ovf, "R7 ovf cleared", tmr_ovf, 0);

    // R2 upper bits ignored
    wcfg(8'hC8);
    t0 = tmr_q; ticks(5);
    chk(tmr_q == 8'(t0 + 5), "R2 upper bits", tmr_q, 8'(t0 + 5));

    // R3/R4 external rising edge, latency
    wcfg(8'h28);
    chk(ext_in_force == 1, "R3 force high", ext_in_force, 1);
    t0 = tmr_q; ticks(10);
    chk(tmr_q == 8'(t0), "R3 cyc_tick ignored", tmr_q, t0);
    ext_pin = 1; repeat (2) @(negedge clk);
    chk(tmr_q == 8'(t0), "R4 rise early", tmr_q, t0);
    @(negedge clk);
    chk(tmr_q == 8'(t0 + 1), "R4 rise due", tmr_q, 8'(t0 + 1));
    ext_pin = 0; repeat (3) @(negedge clk);
    chk(tmr_q == 8'(t0 + 1), "R4 fall ignored", tmr_q, 8'(t0 + 1));

    wcfg(8'h38);
    t0 = tmr_q;
    ext_pin = 1; repeat (3) @(negedge clk);
    chk(tmr_q == 8'(t0), "R4 rise ignored", tmr_q, t0);
    ext_pin = 0; repeat (2) @(negedge clk);
    chk(tmr_q == 8'(t0), "R4 fall early", tmr_q, t0);
    @(negedge clk);
    chk(tmr_q == 8'(t0 + 1), "R4 fall due", tmr_q, 8'(t0 + 1));

    // R5 external source through prescaler, divide by 4
    wcfg(8'h21); wclr;
    t0 = tmr_q;
    pin_pulses(8);
    chk(tmr_q == 8'(t0 + 2), "R5 ext div4", tmr_q, 8'(t0 + 2));
    pin_pulses(7);
    chk(tmr_q == 8'(t0 + 3), "R5 ext div4 b", tmr_q, 8'(t0 + 3));

    // R8 watchdog prescaled
    for (int r = 0; r < 4; r++) begin
      wcfg(8'h08 | 8'(r)); wclr;
      wdt_run(4096, first);
      chk(first == (256 << r), "R8 wdt period", first, 256 << r);
    end

    // R8/R9 undivided watchdog and restart
    wcfg(8'h00); wclr;
    wdt_run(4096, first);
    chk(first == 256, "R8 wdt undivided", first, 256);
    for (int i = 0; i < 200; i++) begin
      wdt_tick = 1; @(negedge clk); wdt_tick = 0;
    end
    wclr;
    wdt_run(4096, first);
    chk(first == 256, "R9 wdt restart", first, 256);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule